// File: doc/BRIEF.md
# Calendar Real-Time Clock with Periodic Timer

This block is a register-mapped real-time clock. It keeps the time of day and the date in one packed calendar word, and it keeps the year as a four-digit BCD value in a second word. A tick-enable input pulses at 32768 Hz. When the clock-watch enable is set, a prescaler turns those pulses into one-second steps. Each step runs through the rollover chain: seconds, minutes, hours, weekday and day of month, month, year, and century. The month lengths follow the Gregorian leap-year rule.

Software reaches the block over a simple 32-bit register bus. A write takes effect on the clock edge, and the read data is combinational from the register state. Software can load the calendar and the year directly, and can program an alarm word and an alarm year. A second interrupt source is a reloadable down-counter that runs on the same tick-enable. It is started and stopped by a control bit.

Both interrupt sources share one set of interrupt registers: raw status, mask, masked status and clear. They drive a single interrupt output.

Top module: `cal_rtc`

## Requirements
- R1: After reset, the calendar reads 0x021E0000 (month 1 in bits 28:25, day 1 in bits 24:20, weekday 7 in bits 19:17, time 00:00:00). The year reads 0x2000. The control, mask, raw status, timer count and timer load registers all read 0.
- R2: A write to offset 0x08 replaces the calendar word at once, and offset 0x00 returns the new value. A write to offset 0x38 replaces the BCD year the same way, and offset 0x30 returns it. The calendar fields are: seconds in bits 5:0, minutes in 11:6, hours in 16:12, weekday in 19:17, day in 24:20 and month in 28:25.
- R3: The calendar advances by one second for every TICKS_PER_SEC tick-enable pulses, counted from the last calendar load. It advances only while bit 26 of the control register (offset 0x0C) is set. While that bit is clear, the calendar word holds its value.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R5: On a day carry, the weekday advances and wraps from 7 to 1. The day of month advances up to the length of the current month and then returns to 1. February has 29 days when the year is divisible by 4 and is not a century year that is not divisible by 400; otherwise it has 28.
- R6: A carry out of month 12 sets the month to 1 and increments the BCD year. The low byte (bits 7:0) counts 00 to 99, and its wrap carries into the century byte (bits 15:8).
- R7: Raw status bit 0 (alarm) sets on the first cycle on which the calendar word equals the alarm word (offset 0x04) and the year equals the alarm year (offset 0x34). It does not set when only one of the two words matches.
- R8: The masked status (offset 0x18) is the raw status (offset 0x14) ANDed with the mask (offset 0x10). The interrupt output is high exactly when the masked status is nonzero.
- R9: Writing a 1 to a bit of offset 0x1C clears that raw status bit. The cleared bit stays clear even while the alarm equality continues to hold.
- R10: Setting bit 1 of the timer control register (offset 0x28) loads the timer count (offset 0x20) from the timer load value (offset 0x24) and starts the timer. Once running, the timer sets raw status bit 1 on every N-th tick-enable pulse, where N is the load value, and reloads at that point. Clearing the bit stops the count.
- R11: A write to the timer load register is ignored while the timer is running. The same write takes effect once the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset of the register accessed |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for regAddr, combinational |
| tickEn | input | 1 | 32768 Hz tick-enable pulse, one clock wide |
| irqOut | output | 1 | Combined interrupt, OR of masked status bits |

## Verification
The assertions on the seconds and weekday steps, and on the year step, assume that every calendar word software loads has fields within their legal ranges. The bench therefore builds each load value from a field model that holds only legal dates and times. The timer-load assertion takes for granted that timer loads change only through the bus, so the bench always stops the timer before it reprograms the period. The bench shortens a second to two tick pulses, which lets it sweep a full hour second by second and every month end across leap, common and century years.

// File: rtl/cal_rtc_pkg.sv
`timescale 1ns/1ps
package cal_rtc_pkg;
  // register offsets
  localparam logic [7:0] A_DATA   = 8'h00;
  localparam logic [7:0] A_MATCH  = 8'h04;
  localparam logic [7:0] A_LOAD   = 8'h08;
  localparam logic [7:0] A_CTRL   = 8'h0C;
  localparam logic [7:0] A_MASK   = 8'h10;
  localparam logic [7:0] A_RAW    = 8'h14;
  localparam logic [7:0] A_MIS    = 8'h18;
  localparam logic [7:0] A_CLR    = 8'h1C;
  localparam logic [7:0] A_TCNT   = 8'h20;
  localparam logic [7:0] A_TLOAD  = 8'h24;
  localparam logic [7:0] A_TCTRL  = 8'h28;
  localparam logic [7:0] A_YEAR   = 8'h30;
  localparam logic [7:0] A_YMATCH = 8'h34;
  localparam logic [7:0] A_YLOAD  = 8'h38;

  localparam int CW_BIT    = 26;
  localparam int TEN_BIT   = 1;
  localparam int IRQ_N     = 2;
  localparam int IRQ_ALARM = 0;
  localparam int IRQ_PER   = 1;
  localparam int CAL_W     = 29;

  // packed calendar fields, msb first, matches the register layout
  typedef struct packed {
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } calFields_t;

  // control -> datapath strobes
  typedef struct packed {
    logic calLoad;
    logic yearLoad;
    logic tmrStart;
    logic cwEn;
    logic tmrEn;
  } strobe_t;

  localparam logic [31:0] CAL_RESET  = 32'h021E_0000;
  localparam logic [15:0] YEAR_RESET = 16'h2000;
endpackage

// File: rtl/cal_rtc_dpath.sv
`timescale 1ns/1ps
module cal_rtc_dpath
  import cal_rtc_pkg::*;
#(
  parameter int TMR_W         = 16,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  strobe_t          strb,
  input  logic [31:0]      wData,
  input  logic [TMR_W-1:0] tmrLoad,
  output logic [31:0]      calWord,
  output logic [15:0]      yearWord,
  output logic [TMR_W-1:0] tmrCount,
  output logic             tmrWrap
);
  localparam int PRE_W = $clog2(TICKS_PER_SEC + 1);

  logic [PRE_W-1:0] preCnt;
  logic             secStep;
  calFields_t       cur;
  calFields_t       nxt;
  logic             yearCarry;
  logic [6:0]       yyBin;
  logic [6:0]       ccBin;
  logic             leapYear;
  logic [4:0]       monthDays;
  logic [8:0]       loInc;
  logic [8:0]       hiInc;

  function automatic logic [8:0] bcdInc(input logic [7:0] v);
    logic [8:0] r;
    if (v[3:0] >= 4'd9) begin
      if (v[7:4] >= 4'd9) r = {1'b1, 8'h00};
      else                r = {1'b0, v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {1'b0, v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // one-second prescaler on the tick enable
  assign secStep = strb.cwEn && tickEn && (preCnt == PRE_W'(TICKS_PER_SEC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (strb.calLoad) preCnt <= '0;
    else if (strb.cwEn && tickEn) preCnt <= secStep ? '0 : preCnt + PRE_W'(1);
  end

  // leap-year rule from the BCD year
  always_comb begin
    yyBin    = 7'(yearWord[7:4]) * 7'd10 + 7'(yearWord[3:0]);
    ccBin    = 7'(yearWord[15:12]) * 7'd10 + 7'(yearWord[11:8]);
    leapYear = (yyBin[1:0] == 2'd0) && ((yyBin != 7'd0) || (ccBin[1:0] == 2'd0));
  end

  always_comb begin
    cur = calFields_t'(calWord[CAL_W-1:0]);
    case (cur.mon)
      4'd2:                      monthDays = leapYear ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   monthDays = 5'd30;
      default:                   monthDays = 5'd31;
    endcase
  end

  // rollover chain
  always_comb begin
    nxt       = cur;
    yearCarry = 1'b0;
    if (cur.sec >= 6'd59) begin
      nxt.sec = '0;
      if (cur.min >= 6'd59) begin
        nxt.min = '0;
        if (cur.hour >= 5'd23) begin
          nxt.hour = '0;
          nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
          if (cur.mday >= monthDays) begin
            nxt.mday = 5'd1;
            if (cur.mon >= 4'd12) begin
              nxt.mon   = 4'd1;
              yearCarry = 1'b1;
            end else begin
              nxt.mon = cur.mon + 4'd1;
            end
          end else begin
            nxt.mday = cur.mday + 5'd1;
          end
        end else begin
          nxt.hour = cur.hour + 5'd1;
        end
      end else begin
        nxt.min = cur.min + 6'd1;
      end
    end else begin
      nxt.sec = cur.sec + 6'd1;
    end
  end

  always_comb begin
    loInc = bcdInc(yearWord[7:0]);
    hiInc = bcdInc(yearWord[15:8]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      calWord <= CAL_RESET;
    end else if (strb.calLoad) begin
      calWord <= wData;
    end else if (secStep) begin
      calWord <= {calWord[31:CAL_W], nxt};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yearWord <= YEAR_RESET;
    end else if (strb.yearLoad) begin
      yearWord <= wData[15:0];
    end else if (secStep && yearCarry) begin
      yearWord <= {loInc[8] ? hiInc[7:0] : yearWord[15:8], loInc[7:0]};
    end
  end

  // periodic down-counter
  assign tmrWrap = strb.tmrEn && tickEn && (tmrCount <= TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) tmrCount <= '0;
    else if (strb.tmrStart) tmrCount <= tmrLoad;
    else if (strb.tmrEn && tickEn) tmrCount <= tmrWrap ? tmrLoad : tmrCount - TMR_W'(1);
  end
endmodule

// File: rtl/cal_rtc_ctrl.sv
`timescale 1ns/1ps
module cal_rtc_ctrl
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWData,
  input  logic [31:0]       calWord,
  input  logic [15:0]       yearWord,
  input  logic [TMR_W-1:0]  tmrCount,
  input  logic              tmrWrap,
  output strobe_t           strb,
  output logic [TMR_W-1:0]  tmrLoad,
  output logic [IRQ_N-1:0]  maskBits,
  output logic [IRQ_N-1:0]  rawBits,
  output logic [31:0]       regRData,
  output logic              irqOut
);
  logic              cwEnR;
  logic              tmrEnR;
  logic [31:0]       matchWord;
  logic [15:0]       yearMatch;
  logic              eqNow;
  logic              eqPrev;
  logic [IRQ_N-1:0]  setBits;
  logic [IRQ_N-1:0]  clrBits;
  logic [IRQ_N-1:0]  rawNext;
  logic [IRQ_N-1:0]  misBits;

  logic wrMatch, wrLoad, wrCtrl, wrMask, wrClr, wrTLoad, wrTCtrl, wrYMatch, wrYLoad;

  always_comb begin
    wrMatch  = regWrEn && (regAddr == ADDR_W'(A_MATCH));
    wrLoad   = regWrEn && (regAddr == ADDR_W'(A_LOAD));
    wrCtrl   = regWrEn && (regAddr == ADDR_W'(A_CTRL));
    wrMask   = regWrEn && (regAddr == ADDR_W'(A_MASK));
    wrClr    = regWrEn && (regAddr == ADDR_W'(A_CLR));
    wrTLoad  = regWrEn && (regAddr == ADDR_W'(A_TLOAD));
    wrTCtrl  = regWrEn && (regAddr == ADDR_W'(A_TCTRL));
    wrYMatch = regWrEn && (regAddr == ADDR_W'(A_YMATCH));
    wrYLoad  = regWrEn && (regAddr == ADDR_W'(A_YLOAD));
  end

  always_comb begin
    strb.calLoad  = wrLoad;
    strb.yearLoad = wrYLoad;
    strb.tmrStart = wrTCtrl && regWData[TEN_BIT] && !tmrEnR;
    strb.cwEn     = cwEnR;
    strb.tmrEn    = tmrEnR;
  end

  // alarm fires on the first cycle of equality
  assign eqNow = (calWord == matchWord) && (yearWord == yearMatch);

  always_comb begin
    setBits            = '0;
    setBits[IRQ_ALARM] = eqNow && !eqPrev;
    setBits[IRQ_PER]   = tmrWrap;
    clrBits            = wrClr ? regWData[IRQ_N-1:0] : '0;
    rawNext            = (rawBits & ~clrBits) | setBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwEnR     <= 1'b0;
      tmrEnR    <= 1'b0;
      matchWord <= '0;
      yearMatch <= '0;
      maskBits  <= '0;
      rawBits   <= '0;
      tmrLoad   <= '0;
      eqPrev    <= 1'b0;
    end else begin
      if (wrCtrl)             cwEnR     <= regWData[CW_BIT];
      if (wrTCtrl)            tmrEnR    <= regWData[TEN_BIT];
      if (wrMatch)            matchWord <= regWData;
      if (wrYMatch)           yearMatch <= regWData[15:0];
      if (wrMask)             maskBits  <= regWData[IRQ_N-1:0];
      if (wrTLoad && !tmrEnR) tmrLoad   <= regWData[TMR_W-1:0];
      eqPrev  <= eqNow;
      rawBits <= rawNext;
    end
  end

  assign misBits = rawBits & maskBits;
  assign irqOut  = |misBits;

  always_comb begin
    regRData = '0;
    case (regAddr)
      ADDR_W'(A_DATA), ADDR_W'(A_LOAD):  regRData = calWord;
      ADDR_W'(A_MATCH):                  regRData = matchWord;
      ADDR_W'(A_CTRL):                   regRData[CW_BIT] = cwEnR;
      ADDR_W'(A_MASK):                   regRData[IRQ_N-1:0] = maskBits;
      ADDR_W'(A_RAW):                    regRData[IRQ_N-1:0] = rawBits;
      ADDR_W'(A_MIS):                    regRData[IRQ_N-1:0] = misBits;
      ADDR_W'(A_TCNT):                   regRData[TMR_W-1:0] = tmrCount;
      ADDR_W'(A_TLOAD):                  regRData[TMR_W-1:0] = tmrLoad;
      ADDR_W'(A_TCTRL):                  regRData[TEN_BIT] = tmrEnR;
      ADDR_W'(A_YEAR), ADDR_W'(A_YLOAD): regRData[15:0] = yearWord;
      ADDR_W'(A_YMATCH):                 regRData[15:0] = yearMatch;
      default:                           regRData = '0;
    endcase
  end
endmodule

// File: rtl/cal_rtc.sv
`timescale 1ns/1ps
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int TMR_W         = 16,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  input  logic              tickEn,
  output logic              irqOut
);
  strobe_t           strb;
  logic [31:0]       calWord;
  logic [15:0]       yearWord;
  logic [TMR_W-1:0]  tmrCount;
  logic [TMR_W-1:0]  tmrLoad;
  logic              tmrWrap;
  logic [IRQ_N-1:0]  maskBits;
  logic [IRQ_N-1:0]  rawBits;

  cal_rtc_ctrl #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWData(regWData), .calWord(calWord), .yearWord(yearWord),
    .tmrCount(tmrCount), .tmrWrap(tmrWrap), .strb(strb), .tmrLoad(tmrLoad),
    .maskBits(maskBits), .rawBits(rawBits), .regRData(regRData), .irqOut(irqOut)
  );

  cal_rtc_dpath #(.TMR_W(TMR_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_dpath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .wData(regWData),
    .tmrLoad(tmrLoad), .calWord(calWord), .yearWord(yearWord),
    .tmrCount(tmrCount), .tmrWrap(tmrWrap)
  );
endmodule

// File: rtl/cal_rtc_chk.sv
`timescale 1ns/1ps
module cal_rtc_chk #(
  parameter int ADDR_W = 8,
  parameter int TMR_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              clrPerBit,
  input logic              irqOut,
  input logic [31:0]       calWord,
  input logic [15:0]       yearWord,
  input logic [TMR_W-1:0]  tmrLoad,
  input logic [1:0]        maskBits,
  input logic              rawPer,
  input logic              tmrWrap,
  input logic              cwEn,
  input logic              tmrEn,
  input logic              calLoad,
  input logic              yearLoad
);
  AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!cwEn && !calLoad) |=> $stable(calWord)); // R3

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(calWord[5:0]) && !$past(calLoad)) |->
      (calWord[5:0] == $past(calWord[5:0]) + 6'd1 || calWord[5:0] == 6'd0)); // R4

  AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(calWord[19:17]) && !$past(calLoad)) |->
      (calWord[19:17] == $past(calWord[19:17]) + 3'd1 || calWord[19:17] == 3'd1)); // R5

  AST_YEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(yearWord) && !$past(yearLoad)) |-> ($past(calWord[28:25]) == 4'd12)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskBits != 2'b00)); // R8

  AST_PER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(8'h1C) && clrPerBit && !tmrWrap) |=> !rawPer); // R9

  AST_TLOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    tmrEn |=> $stable(tmrLoad)); // R11
endmodule

bind cal_rtc cal_rtc_chk #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .clrPerBit(regWData[1]), .irqOut(irqOut), .calWord(calWord),
  .yearWord(yearWord), .tmrLoad(tmrLoad), .maskBits(maskBits),
  .rawPer(rawBits[1]), .tmrWrap(tmrWrap), .cwEn(strb.cwEn),
  .tmrEn(strb.tmrEn), .calLoad(strb.calLoad), .yearLoad(strb.yearLoad)
);

// File: tb/cal_rtc_bench.sv
`timescale 1ns/1ps
module cal_rtc_bench;
  localparam int TPS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWData = 32'h0;
  logic [31:0] regRData;
  logic        tickEn = 1'b0;
  logic        irqOut;

  int checkCnt = 0;
  int failCnt  = 0;

  int mSec, mMin, mHr, mWd, mMd, mMo, mYr;

  always #5 clk = ~clk;

  cal_rtc #(.ADDR_W(8), .TMR_W(16), .TICKS_PER_SEC(TPS)) u_cal_rtc (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .tickEn(tickEn), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRData;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      tickEn = 1'b1;
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  function automatic int daysIn(input int mo, input int yr);
    bit leap;
    leap = ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] packCal();
    return 32'((mMo << 25) | (mMd << 20) | (mWd << 17) | (mHr << 12) | (mMin << 6) | mSec);
  endfunction

  function automatic logic [15:0] packYr(input int y);
    return 16'((((y / 1000) % 10) << 12) | (((y / 100) % 10) << 8) | (((y / 10) % 10) << 4) | (y % 10));
  endfunction

  task automatic modelStep();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHr++;
        if (mHr == 24) begin
          mHr = 0;
          mWd = (mWd == 7) ? 1 : mWd + 1;
          mMd++;
          if (mMd > daysIn(mMo, mYr)) begin
            mMd = 1; mMo++;
            if (mMo == 13) begin mMo = 1; mYr++; end
          end
        end
      end
    end
  endtask

  task automatic setModel(input int y, input int mo, input int md, input int wd,
                          input int h, input int mi, input int s);
    mYr = y; mMo = mo; mMd = md; mWd = wd; mHr = h; mMin = mi; mSec = s;
  endtask

  task automatic loadModel();
    wr(8'h38, {16'h0, packYr(mYr)});
    wr(8'h08, packCal());
  endtask

  task automatic endCase(input int y, input int mo, input int md, input int wd);
    logic [31:0] d;
    setModel(y, mo, md, wd, 23, 59, 59);
    loadModel();
    tick(TPS);
    modelStep();
    rd(8'h00, d);
    chk((mo == 12 && md == 31) ? "R6 calendar at year end" : "R5 calendar at day end", d, packCal());
    rd(8'h30, d);
    chk((mo == 12 && md == 31) ? "R6 year carry" : "R5 year unchanged", d, {16'h0, packYr(mYr)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] frozen;
    logic [31:0] matchVal;
    int yrs[6];
    yrs = '{1999, 2000, 2023, 2024, 2099, 2100};

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 calendar reset", d, 32'h021E_0000);
    rd(8'h30, d); chk("R1 year reset", d, 32'h0000_2000);
    rd(8'h0C, d); chk("R1 control reset", d, 32'h0);
    rd(8'h10, d); chk("R1 mask reset", d, 32'h0);
    rd(8'h14, d); chk("R1 raw reset", d, 32'h0);
    rd(8'h20, d); chk("R1 timer count reset", d, 32'h0);
    rd(8'h24, d); chk("R1 timer load reset", d, 32'h0);
    chk("R1 irq reset", {31'h0, irqOut}, 32'h0);

    // R3 calendar frozen while clock-watch disabled
    tick(10);
    rd(8'h00, d); chk("R3 frozen when disabled", d, 32'h021E_0000);

    // R2 direct loads
    setModel(2031, 7, 14, 2, 9, 41, 17);
    loadModel();
    rd(8'h00, d); chk("R2 calendar load", d, packCal());
    rd(8'h30, d); chk("R2 year load", d, 32'h0000_2031);

    wr(8'h0C, 32'h1 << 26);
    rd(8'h0C, d); chk("R3 control enable readback", d, 32'h0400_0000);

    // R3 exact prescale count
    loadModel();
    tick(TPS - 1);
    rd(8'h00, d); chk("R3 no step before full second", d, packCal());
    tick(1);
    modelStep();
    rd(8'h00, d); chk("R3 step after full second", d, packCal());

    // R4 second-by-second sweep across hour and day boundaries
    setModel(2024, 2, 28, 4, 23, 0, 0);
    loadModel();
    for (int i = 0; i < 3700; i++) begin
      tick(TPS);
      modelStep();
      rd(8'h00, d);
      chk("R4 sweep", d, packCal());
    end

    // R5 R6 month ends over leap, common and century years
    foreach (yrs[k]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        endCase(yrs[k], mo, daysIn(mo, yrs[k]), (mo % 7) + 1);
        if (mo == 2) endCase(yrs[k], 2, 28, 7);
      end
    end

    // R7 alarm
    wr(8'h10, 32'h0);
    setModel(2024, 5, 10, 6, 10, 20, 33);
    matchVal = packCal();
    wr(8'h04, matchVal);
    wr(8'h34, {16'h0, packYr(2024)});
    setModel(2024, 5, 10, 6, 10, 20, 30);
    loadModel();
    wr(8'h1C, 32'h3);
    tick(2 * TPS);
    rd(8'h14, d); chk("R7 alarm not early", d & 32'h1, 32'h0);
    tick(TPS);
    rd(8'h00, d); chk("R7 calendar at match", d, matchVal);
    rd(8'h14, d); chk("R7 alarm raw set", d & 32'h1, 32'h1);

    // R8 masking
    rd(8'h18, d); chk("R8 masked zero with mask clear", d, 32'h0);
    chk("R8 irq low with mask clear", {31'h0, irqOut}, 32'h0);
    wr(8'h10, 32'h1);
    rd(8'h18, d); chk("R8 masked alarm", d, 32'h1);
    chk("R8 irq high", {31'h0, irqOut}, 32'h1);

    // R9 clear while equality holds
    wr(8'h0C, 32'h0);
    wr(8'h1C, 32'h1);
    rd(8'h14, d); chk("R9 alarm cleared", d & 32'h1, 32'h0);
    chk("R9 irq low after clear", {31'h0, irqOut}, 32'h0);
    wr(8'h0C, 32'h1 << 26);

    // R7 year mismatch blocks the alarm
    wr(8'h34, {16'h0, packYr(2025)});
    loadModel();
    wr(8'h1C, 32'h3);
    tick(5 * TPS);
    rd(8'h14, d); chk("R7 no alarm with year mismatch", d & 32'h1, 32'h0);

    // R3 stopping the calendar
    wr(8'h0C, 32'h0);
    rd(8'h00, frozen);
    tick(6 * TPS);
    rd(8'h00, d); chk("R3 frozen after disable", d, frozen);

    // R10 periodic timer
    wr(8'h10, 32'h2);
    wr(8'h24, 32'd5);
    rd(8'h24, d); chk("R10 timer load readback", d, 32'd5);
    wr(8'h1C, 32'h3);
    wr(8'h28, 32'h2);
    rd(8'h20, d); chk("R10 count loaded on start", d, 32'd5);
    tick(4);
    rd(8'h20, d); chk("R10 count after 4 ticks", d, 32'd1);
    rd(8'h14, d); chk("R10 no wrap before period", d & 32'h2, 32'h0);
    tick(1);
    rd(8'h14, d); chk("R10 wrap at period", d & 32'h2, 32'h2);
    chk("R10 irq from timer", {31'h0, irqOut}, 32'h1);
    rd(8'h20, d); chk("R10 reload after wrap", d, 32'd5);
    wr(8'h1C, 32'h2);
    rd(8'h14, d); chk("R9 timer bit cleared", d & 32'h2, 32'h0);
    tick(5);
    rd(8'h14, d); chk("R10 second period", d & 32'h2, 32'h2);

    // R11 load ignored while running
    wr(8'h24, 32'd9);
    rd(8'h24, d); chk("R11 load ignored while running", d, 32'd5);
    wr(8'h28, 32'h0);
    rd(8'h28, d); chk("R10 timer stopped", d, 32'h0);
    rd(8'h20, frozen);
    tick(3);
    rd(8'h20, d); chk("R10 count holds when stopped", d, frozen);
    wr(8'h24, 32'd9);
    rd(8'h24, d); chk("R11 load accepted when stopped", d, 32'd9);

    // R10 sweep of short periods
    for (int n = 1; n <= 6; n++) begin
      wr(8'h28, 32'h0);
      wr(8'h24, 32'(n));
      wr(8'h1C, 32'h2);
      wr(8'h28, 32'h2);
      if (n > 1) begin
        tick(n - 1);
        rd(8'h14, d); chk("R10 sweep no early wrap", d & 32'h2, 32'h0);
      end
      tick(1);
      rd(8'h14, d); chk("R10 sweep wrap", d & 32'h2, 32'h2);
    end
    wr(8'h28, 32'h0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule